// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several requesters build locks and other atomic read-modify-write sequences on one shared array of memory words. A requester reads a word with a load-linked request. That request returns the word and leaves a reservation for that requester on that address. Later the requester sends a store-conditional to the same address. The store-conditional writes only if no other requester has written the word in the meantime, and it reports whether it succeeded. Plain loads and stores are also accepted.

At most one request is served per clock cycle. When several requesters ask in the same cycle, the lowest-numbered one is served and the others see their ready signal low. A stalled requester must keep its request steady until it sees ready. The response comes back on a shared response channel one cycle after acceptance and carries the requester's index.

Opcodes on each requester's 2-bit op field: 0 = load, 1 = store, 2 = load-linked, 3 = store-conditional.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is held, no response is issued. After reset, every word reads 0 and no requester holds a reservation, so a store-conditional issued right after reset returns 0.
- R2: In a cycle where a request is accepted, exactly the lowest-numbered requester with valid high has ready high, and all other ready bits are low. A stalled requester that holds its request is served in a later cycle.
- R3: A request accepted at a clock edge produces rsp_valid at that same edge. rsp_id holds the index of the accepted requester.
- R4: A load (op 0) returns the word at the address in rsp_rdata. A store (op 1) writes the word and returns rsp_ok = 1 with rsp_rdata = 0.
- R5: A load-linked (op 2) returns the addressed word and sets a reservation for that requester on that address.
- R6: A store-conditional (op 3) whose requester holds a reservation on the same address writes the data and returns rsp_ok = 1.
- R7: A store-conditional without a matching reservation leaves memory unchanged and returns rsp_ok = 0.
- R8: A write by any requester, whether a store or a successful store-conditional, clears every other requester's reservation on that address. It does not affect reservations on other addresses.
- R9: A store-conditional always clears the issuing requester's reservation, whether it succeeds or fails.
- R10: A new load-linked replaces the requester's earlier reservation address.
- R11: A requester's own plain store to its reserved address does not clear its reservation.
- R12: When all requesters load-link a lock word holding 0 and then all issue a store-conditional of 1 to it, exactly one succeeds. Given the fixed priority, the winner is the lowest-numbered contender. A plain store of 0 releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_op | input | 2*NREQ | Opcode per requester (0 load, 1 store, 2 load-linked, 3 store-conditional) |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Write data per requester |
| req_ready | output | NREQ | Request accepted this cycle (one-hot or zero) |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | IDW | Index of the requester the response belongs to |
| rsp_rdata | output | DW | Read data for loads and load-linked, else 0 |
| rsp_ok | output | 1 | Store-conditional success; 1 for every other opcode |

## Verification
The hardest situation to reach is a reservation being broken by another requester between a load-linked and its store-conditional, while several requesters contend for the same word. Directed sequences set up each interleaving on purpose: a foreign store, a foreign store to a different word, the requester's own store, a re-link and a failed store-conditional. All-requester races on a lock word then test single-winner behaviour. A random phase uses only two addresses, so that collisions and broken reservations happen often. A behavioural model compares every output on every cycle.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 8,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [2*NREQ-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic [NREQ-1:0]   req_ready,
  output logic              rsp_valid,
  output logic [IDW-1:0]    rsp_id,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_ok
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]   mem    [DEPTH];
  logic [NREQ-1:0] resv_v;
  logic [AW-1:0]   resv_a [NREQ];

  logic [IDW-1:0] gid;
  logic           any;
  logic [1:0]     op;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wd;
  logic           resv_hit, wr;

  always_comb begin
    gid = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req_valid[i]) gid = IDW'(i);
  end

  assign any       = |req_valid;
  assign req_ready = any ? (NREQ'(1) << gid) : '0;
  assign op        = req_op[gid*2 +: 2];
  assign addr      = req_addr[gid*AW +: AW];
  assign wd        = req_wdata[gid*DW +: DW];
  assign resv_hit  = resv_v[gid] && (resv_a[gid] == addr);
  assign wr        = any && (op == OP_ST || (op == OP_SC && resv_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      for (int i = 0; i < NREQ; i++) resv_a[i] <= '0;
      resv_v    <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= any;
      rsp_id    <= any ? gid : '0;
      rsp_rdata <= (any && (op == OP_LD || op == OP_LL)) ? mem[addr] : '0;
      rsp_ok    <= any && (op != OP_SC || resv_hit);
      if (wr) mem[addr] <= wd;
      for (int i = 0; i < NREQ; i++)
        if (wr && IDW'(i) != gid && resv_a[i] == addr) resv_v[i] <= 1'b0;
      if (any && op == OP_LL) begin
        resv_v[gid] <= 1'b1;
        resv_a[gid] <= addr;
      end
      if (any && op == OP_SC) resv_v[gid] <= 1'b0;
    end
  end

  AST_ONE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> rsp_valid); // R3

  for (genvar g = 0; g < NREQ; g++) begin : g_chk
    localparam logic [NREQ-1:0] LOWER = NREQ'((64'd1 << g) - 64'd1);
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[g] |-> (req_valid[g] && (req_valid & LOWER) == '0)); // R2
    AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[g] && req_op[g*2 +: 2] == OP_LL) |=> resv_v[g]); // R5
    AST_SC_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[g] && req_op[g*2 +: 2] == OP_SC && !resv_v[g]) |=> (rsp_valid && !rsp_ok)); // R7
    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[g] && req_op[g*2 +: 2] == OP_SC) |=> !resv_v[g]); // R9
  end
endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int N = 4, AW = 4, DW = 8, IDW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] req_ready;
  logic rsp_valid, rsp_ok;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_rdata;

  llsc_monitor #(.NREQ(N), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, ok_count = 0;
  logic [DW-1:0] last_data;
  logic last_ok;
  logic [IDW-1:0] last_id;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m [16];
  bit rv [N];
  int ra [N];
  bit e_rv; int e_id, e_data; bit e_ok; string e_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[k]) m[k] = 0;
      foreach (rv[i]) begin rv[i] = 0; ra[i] = 0; end
      e_rv = 0; e_id = 0; e_data = 0; e_ok = 0; e_tag = "R1";
    end else begin
      int g; g = -1;
      for (int i = N - 1; i >= 0; i--) if (req_valid[i]) g = i;
      e_rv = 0; e_id = 0; e_data = 0; e_ok = 0; e_tag = "R3";
      if (g >= 0) begin
        int op, a, d; bit w;
        op = req_op[g*2 +: 2]; a = req_addr[g*AW +: AW]; d = req_wdata[g*DW +: DW];
        e_rv = 1; e_id = g; e_ok = 1; w = 0;
        if (op == 0) begin e_data = m[a]; e_tag = "R4"; end
        else if (op == 1) begin w = 1; e_tag = "R4"; end
        else if (op == 2) begin e_data = m[a]; rv[g] = 1; ra[g] = a; e_tag = "R5"; end
        else begin
          e_ok = rv[g] && ra[g] == a; w = e_ok; rv[g] = 0;
          e_tag = e_ok ? "R6" : "R7";
        end
        if (w) begin
          m[a] = d;
          for (int i = 0; i < N; i++) if (i != g && ra[i] == a) rv[i] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    int g; g = -1;
    for (int i = N - 1; i >= 0; i--) if (req_valid[i]) g = i;
    check("R2 ready", req_ready, (g >= 0) ? (1 << g) : 0);
    check({e_tag, " rsp_valid"}, rsp_valid, e_rv);
    if (e_rv) begin
      check({e_tag, " rsp_id"}, rsp_id, e_id);
      check({e_tag, " rsp_rdata"}, rsp_rdata, e_data);
      check({e_tag, " rsp_ok"}, rsp_ok, e_ok);
    end
    if (rsp_valid && rsp_ok) ok_count++;
  end

  task automatic set_req(int i, int op, int a, int d);
    req_valid[i] = 1; req_op[i*2 +: 2] = 2'(op);
    req_addr[i*AW +: AW] = AW'(a); req_wdata[i*DW +: DW] = DW'(d);
  endtask

  task automatic do_op(int i, int op, int a, int d);
    @(negedge clk); #1;
    set_req(i, op, a, d);
    do @(negedge clk); while (!req_ready[i]);
    last_data = rsp_rdata; last_ok = rsp_ok; last_id = rsp_id;
    #1 req_valid[i] = 0;
  endtask

  task automatic all_op(int op, int a, int d, logic [N-1:0] who);
    logic [N-1:0] pend;
    @(negedge clk); #1;
    for (int i = 0; i < N; i++) if (who[i]) set_req(i, op, a, d);
    pend = who;
    while (pend != 0) begin
      @(negedge clk);
      pend &= ~req_ready;
      #1 req_valid = pend;
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      forever begin
        @(posedge clk); wd++;
        if (wd > 20000) begin
          errors++; checks++;
          $display("FAIL watchdog actual=hung expected=done");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    #1 rst_n = 1;

    do_op(1, 0, 5, 0);      check("R1 word after reset", last_data, 0);
    do_op(2, 3, 3, 7);      check("R1 sc after reset", last_ok, 0);
    do_op(0, 1, 5, 'hA5);   check("R4 store ok", last_ok, 1);
    do_op(3, 0, 5, 0);      check("R4 load", last_data, 'hA5); check("R3 id", last_id, 3);
    do_op(1, 2, 7, 0);      check("R5 ll data", last_data, 0);
    do_op(1, 3, 7, 'h3C);   check("R6 sc ok", last_ok, 1);
    do_op(0, 0, 7, 0);      check("R6 written", last_data, 'h3C);
    do_op(1, 3, 7, 'h44);   check("R9 sc after success", last_ok, 0);
    do_op(2, 2, 8, 0);
    do_op(2, 3, 9, 'h55);   check("R7 sc wrong addr", last_ok, 0);
    do_op(2, 3, 8, 'h56);   check("R9 sc after failed sc", last_ok, 0);
    do_op(2, 0, 9, 0);      check("R7 no write 9", last_data, 0);
    do_op(2, 0, 8, 0);      check("R7 no write 8", last_data, 0);
    do_op(0, 2, 2, 0);
    do_op(3, 1, 2, 'h11);
    do_op(0, 3, 2, 'h22);   check("R8 foreign store breaks", last_ok, 0);
    do_op(1, 0, 2, 0);      check("R8 data kept", last_data, 'h11);
    do_op(0, 2, 2, 0);
    do_op(3, 1, 4, 'h12);
    do_op(0, 3, 2, 'h22);   check("R8 other addr no effect", last_ok, 1);
    do_op(2, 2, 6, 0);
    do_op(2, 1, 6, 5);
    do_op(2, 3, 6, 9);      check("R11 own store keeps", last_ok, 1);
    do_op(3, 2, 10, 0);
    do_op(3, 2, 11, 0);
    do_op(3, 3, 10, 1);     check("R10 old addr dropped", last_ok, 0);
    do_op(3, 2, 10, 0);
    do_op(3, 2, 11, 0);
    do_op(3, 3, 11, 1);     check("R10 new addr kept", last_ok, 1);

    all_op(2, 0, 0, 4'b1111);
    ok_count = 0;
    all_op(3, 0, 1, 4'b1111);
    @(negedge clk);
    check("R12 single winner", ok_count, 1);
    do_op(3, 0, 0, 0);      check("R12 lock held", last_data, 1);
    do_op(2, 1, 0, 0);
    do_op(1, 0, 0, 0);      check("R12 released", last_data, 0);
    all_op(2, 0, 0, 4'b1110);
    @(negedge clk); ok_count = 0;
    @(negedge clk); #1;
    for (int i = 1; i < N; i++) set_req(i, 3, 0, 1);
    @(negedge clk);
    check("R2 lowest served", req_ready, 4'b0010);
    check("R12 lowest contender wins", rsp_ok, 1);
    #1 req_valid = 0;
    repeat (2) @(negedge clk);
    check("R12 one winner again", ok_count, 1);

    for (int c = 0; c < 400; c++) begin
      @(negedge clk); #1;
      for (int i = 0; i < N; i++)
        if (!req_valid[i] || req_ready[i]) begin
          if ($urandom_range(0, 2) != 0)
            set_req(i, $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 255));
          else req_valid[i] = 0;
        end
    end
    @(negedge clk); #1 req_valid = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule